// File: doc/BRIEF.md
# LSB rounding reducer

This block narrows a fixed-point word by removing a parameter-set number of low-order bits. It is meant for the end of an arithmetic stage. A typical case is an adder or subtractor whose result is one bit wider than the datapath and must return to the datapath width without a bias. The operand may be two's complement or unsigned. The low bits are either rounded to the nearest output code or discarded.

Rounding of signed data is symmetric: exact halves move away from zero, so the long-run average of the output does not drift. Rounding can carry the largest positive input past the top output code. When that happens the block either wraps, which is the plain modular result, or saturates at the top code when clipping is enabled.

Two register chains sit around the arithmetic: one on the input side and one on the output side. Each has its own parameter depth, and either can be zero. A valid flag travels through the same chains, so it always stays aligned with its data.

Top module: `lsb_round_reducer`

## Requirements
- R1: With signed data and rounding on, an input lying exactly halfway between two output codes goes to the code farther from zero. Any other input goes to the nearest code. For a 3-bit input reduced by one bit, the input codes 0,1,2,3,-4,-3,-2,-1 give 0,1,1,2,-2,-2,-1,-1 before any overflow handling.
- R2: With unsigned data and rounding on, an exact half rounds up and any other input goes to the nearest code.
- R3: With rounding off, the low bits are discarded, which is floor for signed data. For a 3-bit signed input reduced by one bit, the input codes 0,1,2,3,-4,-3,-2,-1 give 0,0,1,1,-2,-2,-1,-1.
- R4: Signed rounding has zero mean over any input range that is symmetric about zero and contains no overflowing input. In particular, the output sum over all inputs from -503 to 503 at 10-to-6 bits is 0.
- R5: With clipping on, a rounded result above the largest output code is replaced by that code. The largest code is 2^(OUT_W-1)-1 for signed data and 2^OUT_W-1 for unsigned data.
- R6: With clipping off, a rounded result above the largest output code wraps modulo 2^OUT_W. It becomes -2^(OUT_W-1) for signed data and 0 for unsigned data.
- R7: When OUT_W equals IN_W, the output word equals the input word after the pipeline delay.
- R8: Output data and valid appear IN_STAGES+OUT_STAGES cycles after the input. When both depths are zero, the output is combinational.
- R9: While reset is asserted, every register stage holds zero. The output word and the output valid are therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register stages |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks in_word as carrying a sample |
| in_word | input | IN_W | Wide operand, signed or unsigned per SIGNED_MODE |
| out_valid | output | 1 | in_valid delayed by the total stage count |
| out_word | output | OUT_W | Reduced result |

## Verification
The bench targets the exact-half codes. A design that rounds halves upward in signed mode fails R1 on negative halves and shows a nonzero sum over the symmetric sweep. The top input code is driven with clipping both on and off: a missing saturation lets the result wrap to the most negative code or to zero, and a missing wrap shows as a clipped value. Instances with zero, one and three stages catch any valid/data misalignment by a single cycle. The equal-width instance exposes a reducer that alters data which needs no narrowing.

// File: rtl/lsbr_pkg.sv
`timescale 1ns/1ps
package lsbr_pkg;

  // Largest code representable in w bits.
  function automatic int lsbr_code_max(int w, bit sgn);
    return sgn ? (1 << (w - 1)) - 1 : (1 << w) - 1;
  endfunction

  // Code produced when the top code is exceeded by one and wraps.
  function automatic int lsbr_wrap_code(int w, bit sgn);
    return sgn ? -(1 << (w - 1)) : 0;
  endfunction

endpackage

// File: rtl/lsbr_stage_chain.sv
`timescale 1ns/1ps
module lsbr_stage_chain #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  output logic [W-1:0] q_data
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q_valid = d_valid;
      assign q_data  = d_data;
    end else begin : g_regs
      logic [W:0] pipe_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
        end else begin
          pipe_q[0] <= {d_valid, d_data};
          for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
        end
      end

      assign q_valid = pipe_q[DEPTH-1][W];
      assign q_data  = pipe_q[DEPTH-1][W-1:0];
    end
  endgenerate

endmodule

// File: rtl/lsbr_round_core.sv
`timescale 1ns/1ps
module lsbr_round_core
  import lsbr_pkg::*;
#(
  parameter int IN_W        = 12,
  parameter int OUT_W       = 8,
  parameter bit SIGNED_MODE = 1'b1,
  parameter bit ROUND_EN    = 1'b1,
  parameter bit CLIP_EN     = 1'b0
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  localparam int DROP = IN_W - OUT_W;

  generate
    if (DROP == 0) begin : g_pass
      assign dout = din;
    end else begin : g_reduce
      localparam int EXT_W = IN_W + 2;
      localparam logic signed [EXT_W-1:0] HALF  = EXT_W'(1) <<< (DROP - 1);
      localparam logic signed [EXT_W-1:0] STEP  = EXT_W'(1) <<< DROP;
      localparam logic signed [EXT_W-1:0] MAXC  = EXT_W'(lsbr_code_max(OUT_W, SIGNED_MODE));
      localparam logic signed [EXT_W-1:0] WRAPC = EXT_W'(lsbr_wrap_code(OUT_W, SIGNED_MODE));

      function automatic logic signed [EXT_W-1:0] f_extend_in(input logic [IN_W-1:0] d);
        if (SIGNED_MODE) return EXT_W'(signed'(d));
        return signed'(EXT_W'(d));
      endfunction

      function automatic logic signed [EXT_W-1:0] f_extend_out(input logic [OUT_W-1:0] d);
        if (SIGNED_MODE) return EXT_W'(signed'(d));
        return signed'(EXT_W'(d));
      endfunction

      // Half an output LSB toward the magnitude; one less for negatives.
      function automatic logic signed [EXT_W-1:0] f_bias(input logic signed [EXT_W-1:0] x);
        if (!ROUND_EN) return '0;
        if (SIGNED_MODE && x < 0) return HALF - 1;
        return HALF;
      endfunction

      function automatic logic f_over(input logic signed [EXT_W-1:0] s);
        return ROUND_EN && (s > MAXC);
      endfunction

      logic signed [EXT_W-1:0] x_ext;
      logic signed [EXT_W-1:0] sum_w;
      logic signed [EXT_W-1:0] shifted;
      logic signed [EXT_W-1:0] out_ext;
      logic signed [EXT_W-1:0] resid;
      logic                    round_ovf;

      always_comb begin
        x_ext     = f_extend_in(din);
        sum_w     = x_ext + f_bias(x_ext);
        shifted   = sum_w >>> DROP;
        round_ovf = f_over(shifted);
        dout      = (CLIP_EN && round_ovf) ? MAXC[OUT_W-1:0] : shifted[OUT_W-1:0];
        out_ext   = f_extend_out(dout);
        resid     = x_ext - (out_ext <<< DROP);

        if (!round_ovf) begin
          if (!ROUND_EN) begin
            assert_trunc_floor_R3: assert (resid >= 0 && resid < STEP)
              else $error("truncation residue out of range");
          end else if (SIGNED_MODE) begin
            assert_round_away_R1: assert (resid >= -HALF && resid <= HALF &&
                                          (resid != HALF || x_ext < 0) &&
                                          (resid != -HALF || x_ext >= 0))
              else $error("signed rounding residue wrong");
          end else begin
            assert_round_up_R2: assert (resid >= -HALF && resid < HALF)
              else $error("unsigned rounding residue wrong");
          end
        end else if (CLIP_EN) begin
          assert_clip_sat_R5: assert (resid >= HALF)
            else $error("clipped result not below input");
        end else begin
          assert_wrap_code_R6: assert (out_ext == WRAPC)
            else $error("overflow did not wrap to bottom code");
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lsb_round_reducer.sv
`timescale 1ns/1ps
module lsb_round_reducer #(
  parameter int IN_W        = 12,
  parameter int OUT_W       = 8,
  parameter bit SIGNED_MODE = 1'b1,
  parameter bit ROUND_EN    = 1'b1,
  parameter bit CLIP_EN     = 1'b0,
  parameter int IN_STAGES   = 1,
  parameter int OUT_STAGES  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_word,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);

  generate
    if (OUT_W > IN_W) begin : g_bad_width
      $error("OUT_W must not exceed IN_W");
    end
  endgenerate

  logic             pre_valid;
  logic [IN_W-1:0]  pre_word;
  logic [OUT_W-1:0] core_word;

  lsbr_stage_chain #(.W(IN_W), .DEPTH(IN_STAGES)) u_in_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_data  (in_word),
    .q_valid (pre_valid),
    .q_data  (pre_word)
  );

  lsbr_round_core #(
    .IN_W        (IN_W),
    .OUT_W       (OUT_W),
    .SIGNED_MODE (SIGNED_MODE),
    .ROUND_EN    (ROUND_EN),
    .CLIP_EN     (CLIP_EN)
  ) u_core (
    .din  (pre_word),
    .dout (core_word)
  );

  lsbr_stage_chain #(.W(OUT_W), .DEPTH(OUT_STAGES)) u_out_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (pre_valid),
    .d_data  (core_word),
    .q_valid (out_valid),
    .q_data  (out_word)
  );

endmodule

// File: tb/lsb_round_reducer_tb_top.sv
`timescale 1ns/1ps
module lsb_round_reducer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vin;
  logic [15:0] stim;

  always #4 clk = ~clk;   // 125 MHz

  logic       v_s3r, v_s3t, v_s3c, v_u4r, v_u4c, v_dut, v_eq;
  logic [1:0] o_s3r, o_s3t, o_s3c, o_u4r, o_u4c;
  logic [5:0] o_dut, o_eq;

  lsb_round_reducer #(.IN_W(3), .OUT_W(2), .SIGNED_MODE(1), .ROUND_EN(1), .CLIP_EN(0),
    .IN_STAGES(1), .OUT_STAGES(1)) u_s3r (.clk(clk), .rst_n(rst_n), .in_valid(vin),
    .in_word(stim[2:0]), .out_valid(v_s3r), .out_word(o_s3r));
  lsb_round_reducer #(.IN_W(3), .OUT_W(2), .SIGNED_MODE(1), .ROUND_EN(0), .CLIP_EN(0),
    .IN_STAGES(0), .OUT_STAGES(0)) u_s3t (.clk(clk), .rst_n(rst_n), .in_valid(vin),
    .in_word(stim[2:0]), .out_valid(v_s3t), .out_word(o_s3t));
  lsb_round_reducer #(.IN_W(3), .OUT_W(2), .SIGNED_MODE(1), .ROUND_EN(1), .CLIP_EN(1),
    .IN_STAGES(0), .OUT_STAGES(1)) u_s3c (.clk(clk), .rst_n(rst_n), .in_valid(vin),
    .in_word(stim[2:0]), .out_valid(v_s3c), .out_word(o_s3c));
  lsb_round_reducer #(.IN_W(4), .OUT_W(2), .SIGNED_MODE(0), .ROUND_EN(1), .CLIP_EN(0),
    .IN_STAGES(1), .OUT_STAGES(0)) u_u4r (.clk(clk), .rst_n(rst_n), .in_valid(vin),
    .in_word(stim[3:0]), .out_valid(v_u4r), .out_word(o_u4r));
  lsb_round_reducer #(.IN_W(4), .OUT_W(2), .SIGNED_MODE(0), .ROUND_EN(1), .CLIP_EN(1),
    .IN_STAGES(0), .OUT_STAGES(0)) u_u4c (.clk(clk), .rst_n(rst_n), .in_valid(vin),
    .in_word(stim[3:0]), .out_valid(v_u4c), .out_word(o_u4c));
  lsb_round_reducer #(.IN_W(10), .OUT_W(6), .SIGNED_MODE(1), .ROUND_EN(1), .CLIP_EN(0),
    .IN_STAGES(2), .OUT_STAGES(1)) dut_i (.clk(clk), .rst_n(rst_n), .in_valid(vin),
    .in_word(stim[9:0]), .out_valid(v_dut), .out_word(o_dut));
  lsb_round_reducer #(.IN_W(6), .OUT_W(6), .SIGNED_MODE(1), .ROUND_EN(1), .CLIP_EN(0),
    .IN_STAGES(1), .OUT_STAGES(1)) u_eq (.clk(clk), .rst_n(rst_n), .in_valid(vin),
    .in_word(stim[5:0]), .out_valid(v_eq), .out_word(o_eq));

  int n_checks = 0;
  int n_fail   = 0;
  int n        = 0;
  int msum     = 0;
  int hist  [4096];
  bit vhist [4096];
  bit ptag  [4096];

  // 3-bit signed input codes 0..7 reduced by one bit (R1, R3 tables).
  int round3 [8] = '{0, 1, 1, 2, -2, -2, -1, -1};
  int trunc3 [8] = '{0, 0, 1, 1, -2, -2, -1, -1};

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (step %0d)", req, act, exp, n);
    end
  endtask

  function automatic int h(int k);
    return (k < 0) ? 0 : hist[k];
  endfunction

  function automatic int hv(int k);
    return (k < 0) ? 0 : int'(vhist[k]);
  endfunction

  // Reference model: integer arithmetic on the value, then wrap or clip.
  function automatic int exp_code(int raw, int in_w, int out_w, bit sgn, bit rnd, bit clp);
    int s, v, q, maxc;
    s = 1 << (in_w - out_w);
    v = raw & ((1 << in_w) - 1);
    if (sgn && v >= (1 << (in_w - 1))) v = v - (1 << in_w);
    if (rnd) begin
      if (v >= 0) q = (v + s / 2) / s;
      else        q = -((-v + s / 2) / s);
    end else begin
      if (v >= 0) q = v / s;
      else        q = -((-v + s - 1) / s);
    end
    maxc = sgn ? (1 << (out_w - 1)) - 1 : (1 << out_w) - 1;
    if (q > maxc) q = clp ? maxc : q - (1 << out_w);
    return q & ((1 << out_w) - 1);
  endfunction

  task automatic do_checks();
    int e;
    e = round3[h(n-2) & 7];
    if (e == 2) e = -2;
    chk("R1 R6 s3r data", int'($signed(o_s3r)), e);
    chk("R8 s3r valid", int'(v_s3r), hv(n-2));
    chk("R3 R8 s3t data", int'($signed(o_s3t)), trunc3[h(n) & 7]);
    chk("R8 s3t valid", int'(v_s3t), hv(n));
    e = round3[h(n-1) & 7];
    if (e == 2) e = 1;
    chk("R1 R5 s3c data", int'($signed(o_s3c)), e);
    chk("R8 s3c valid", int'(v_s3c), hv(n-1));
    chk("R2 R6 u4r data", int'(o_u4r), exp_code(h(n-1), 4, 2, 1'b0, 1'b1, 1'b0));
    chk("R8 u4r valid", int'(v_u4r), hv(n-1));
    chk("R2 R5 u4c data", int'(o_u4c), exp_code(h(n), 4, 2, 1'b0, 1'b1, 1'b1));
    chk("R8 u4c valid", int'(v_u4c), hv(n));
    chk("R1 R8 dut data", int'(o_dut), exp_code(h(n-3), 10, 6, 1'b1, 1'b1, 1'b0));
    chk("R8 dut valid", int'(v_dut), hv(n-3));
    chk("R7 eq data", int'(o_eq), h(n-2) & 63);
    chk("R8 eq valid", int'(v_eq), hv(n-2));
    if (n >= 3 && ptag[n-3]) msum += int'($signed(o_dut));
  endtask

  task automatic step(int s, bit v, bit tag);
    stim     = 16'(s);
    vin      = v;
    hist[n]  = s & 16'hFFFF;
    vhist[n] = v;
    ptag[n]  = tag;
    #1;
    do_checks();
    n++;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    stim  = 16'hFFFF;
    vin   = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R9 reset dut valid", int'(v_dut), 0);
    chk("R9 reset dut data", int'(o_dut), 0);
    chk("R9 reset eq data", int'(o_eq), 0);
    chk("R9 reset s3r valid", int'(v_s3r), 0);
    @(negedge clk);
    stim = 16'h0;
    vin  = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // Directed sweep: every code of the small instances.
    for (int k = 0; k < 256; k++) step(k, (k % 3) != 0, 1'b0);
    // Symmetric range for the zero-mean requirement.
    for (int v = -503; v <= 503; v++) step(v & 1023, 1'b1, 1'b1);
    // Top codes back to back, then random traffic.
    step(511, 1'b1, 1'b0);
    step(15, 1'b1, 1'b0);
    step(3, 1'b1, 1'b0);
    for (int k = 0; k < 1500; k++) step(int'($urandom & 32'hFFFF), ($urandom % 4) != 0, 1'b0);
    for (int k = 0; k < 4; k++) step(0, 1'b0, 1'b0);

    chk("R4 symmetric mean sum", msum, 0);
    summary();
    $finish;
  end

endmodule